// File: doc/BRIEF.md
# Raw-Bitstream Zero-Density Fast Detector

This block watches the undecimated one-bit output of a sigma-delta modulator and flags an over-current within a few modulator clocks. It keeps a running count of the zero bits among the most recent bits, over a window whose length software sets between 4 and 32 bits. Each time the count goes above a maximum-zeros limit or below a minimum-zeros limit, the block raises an error. A trip stage latches that error into a sticky trip output and into two cause flags that say which limit was crossed. Only an explicit clear drops them.

The modulator bit arrives with a one-cycle bit-clock enable in the system clock domain. After reset, and again after every change of the effective window length, the history is flushed. The block then blanks its comparisons until 32 bits have been accepted, so a window that is only partly filled cannot cause a false trip.

Top module: `bitwin_fast_detect`

## Requirements
- R1: While reset is held low at a clock edge, and right after it, fd_err, trip_out and both cause bits are 0.
- R2: The effective window length is win_len clamped to the range 4..32. A value below 4 acts as 4 and a value above 32 acts as 32.
- R3: The zero count equals the number of 0 bits among the last L accepted bits, where L is the effective window length. Slots not yet filled since the last flush count as ones.
- R4: fd_err stays 0 until 32 bits have been accepted since the last reset or flush, even when the count is outside the limits.
- R5: Once armed, a zero count greater than zmax_lim drives fd_err high, and at the next edge trip_out and cause bit 0 (above-max) are set.
- R6: Once armed, a zero count less than zmin_lim drives fd_err high, and at the next edge trip_out and cause bit 1 (below-min) are set.
- R7: trip_out and the cause bits stay set until a cycle in which trip_clr is 1 and fd_err is 0. After that edge they are all 0. When fd_err is 1, it takes priority over trip_clr.
- R8: In a cycle with bit_en low, bit_in is ignored: the count and the blanking progress are unchanged.
- R9: A change of the effective window length flushes the history and restarts the 32-bit blanking period. The bit offered in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Modulator bit-clock enable, one cycle per bit |
| bit_in | input | 1 | Modulator data bit |
| win_len | input | 6 | Requested window length in bits |
| zmax_lim | input | 6 | Maximum allowed zero count |
| zmin_lim | input | 6 | Minimum allowed zero count |
| trip_clr | input | 1 | Clears the trip output and cause bits |
| fd_err | output | 1 | Live limit-violation error |
| trip_out | output | 1 | Sticky trip-zone output |
| cause | output | 2 | Sticky cause: bit 0 above-max, bit 1 below-min |

## Verification
The bench aims at the edge of the blanking period: an all-zero stream against a zero maximum must stay quiet for 31 bits and fire on the 32nd. A design that is off by one in the counter would trip early or late. Out-of-range window requests check the clamp, because an unclamped length would read the wrong leaving bit and the count would drift. A clear issued while the fault persists must leave the trip set, which a design that gives the clear priority would get wrong. Gaps in the enable and length changes made mid-stream check that idle cycles do not move the count. They also check that a new window starts from a clean history rather than from a stale count.

// File: rtl/fd_pkg.sv
// Shared definitions for the bitstream fast detector.
// Assumes: cause vector bit positions are fixed and visible at the top port.
package fd_pkg;
    localparam int CAUSE_OVER  = 0;   // zero count above maximum
    localparam int CAUSE_UNDER = 1;   // zero count below minimum
    typedef logic [1:0] cause_t;
endpackage

// File: rtl/fd_window.sv
// Sliding-window zero counter over the raw modulator bitstream.
// Keeps MAXWIN bits of history (bit 0 newest) and updates the zero count
// incrementally from the entering bit and the bit leaving at length eff.
// Assumes: eff is already clamped to 1..MAXWIN; flush reloads all-ones.
module fd_window #(
    parameter int MAXWIN = 32,
    parameter int CW     = $clog2(MAXWIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          bit_en,
    input  logic          bit_in,
    input  logic [CW-1:0] eff,
    output logic [CW-1:0] zcnt
);
    localparam int IW = $clog2(MAXWIN);

    logic [MAXWIN-1:0] hist;
    logic [CW-1:0]     effm1;
    logic              enter_z;
    logic              leave_z;

    // Locate the bit about to leave the window.
    always_comb begin
        effm1   = eff - CW'(1);
        enter_z = ~bit_in;
        leave_z = ~hist[effm1[IW-1:0]];
    end

    // Shift history and adjust the zero count on each accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            hist <= '1;
            zcnt <= '0;
        end else if (bit_en) begin
            hist <= {hist[MAXWIN-2:0], bit_in};
            zcnt <= zcnt + CW'(enter_z) - CW'(leave_z);
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        zcnt <= CW'(MAXWIN)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !flush) |=> $stable(zcnt)); // R8
    AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (zcnt == '0)); // R9
endmodule

// File: rtl/fd_blank.sv
// Start-up blanking and window-change detection.
// Counts accepted bits up to BLANK after reset or a length change, and
// requests a history flush whenever the effective length differs from
// the registered one.
// Assumes: eff is clamped; a flush cycle drops the offered bit.
module fd_blank #(
    parameter int BLANK  = 32,
    parameter int MINWIN = 4,
    parameter int CW     = 6,
    parameter int BW     = $clog2(BLANK + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic [CW-1:0] eff,
    output logic          flush,
    output logic          armed
);
    logic [CW-1:0] len_q;
    logic [BW-1:0] bcnt;

    // Decode change and armed state.
    always_comb begin
        flush = (eff != len_q);
        armed = (bcnt == BW'(BLANK));
    end

    // Track the length in use and advance the blanking count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= CW'(MINWIN);
            bcnt  <= '0;
        end else if (flush) begin
            len_q <= eff;
            bcnt  <= '0;
        end else if (bit_en && !armed) begin
            bcnt  <= bcnt + BW'(1);
        end
    end

    AST_RESTART_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !armed); // R9
    AST_ARM_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !flush) |=> armed); // R4
endmodule

// File: rtl/fd_trip.sv
// Limit comparison and sticky trip-zone stage.
// Raises the live error when armed and the count is outside
// [zmin, zmax]; latches trip and per-limit cause until a clear arrives
// in a fault-free cycle.
// Assumes: an active error takes priority over the clear.
module fd_trip
    import fd_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          armed,
    input  logic [CW-1:0] zcnt,
    input  logic [CW-1:0] zmax,
    input  logic [CW-1:0] zmin,
    input  logic          trip_clr,
    output logic          fd_err,
    output logic          trip_out,
    output cause_t        cause
);
    logic over_m;
    logic under_m;

    // Compare the count against both limits.
    always_comb begin
        over_m  = (zcnt > zmax);
        under_m = (zcnt < zmin);
        fd_err  = armed && (over_m || under_m);
    end

    // Latch trip and cause, clear only when no fault is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trip_out <= 1'b0;
            cause    <= '0;
        end else if (fd_err) begin
            trip_out            <= 1'b1;
            cause[CAUSE_OVER]   <= cause[CAUSE_OVER]  | over_m;
            cause[CAUSE_UNDER]  <= cause[CAUSE_UNDER] | under_m;
        end else if (trip_clr) begin
            trip_out <= 1'b0;
            cause    <= '0;
        end
    end

    AST_ERR_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        fd_err |=> trip_out); // R7
    AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_out && !trip_clr) |=> trip_out); // R7
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_clr && !fd_err) |=> (!trip_out && cause == '0)); // R7
    AST_QUIET_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !trip_out) |=> !trip_out); // R4
    AST_OVER_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && over_m) |=> cause[CAUSE_OVER]); // R5
    AST_UNDER_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && under_m) |=> cause[CAUSE_UNDER]); // R6
endmodule

// File: rtl/bitwin_fast_detect.sv
// Raw-bitstream zero-density fast over-current detector.
// Clamps the requested window, counts zeros in the sliding window,
// blanks after reset or length change, and drives a sticky trip output.
// Assumes: bit_en is a single-cycle strobe synchronous to clk.
module bitwin_fast_detect
    import fd_pkg::*;
#(
    parameter int MAXWIN = 32,
    parameter int MINWIN = 4,
    parameter int BLANK  = 32,
    parameter int CW     = $clog2(MAXWIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          bit_in,
    input  logic [CW-1:0] win_len,
    input  logic [CW-1:0] zmax_lim,
    input  logic [CW-1:0] zmin_lim,
    input  logic          trip_clr,
    output logic          fd_err,
    output logic          trip_out,
    output logic [1:0]    cause
);
    localparam logic [CW-1:0] LO_W = CW'(MINWIN);
    localparam logic [CW-1:0] HI_W = CW'(MAXWIN);

    logic [CW-1:0] eff;
    logic [CW-1:0] zcnt;
    logic          flush;
    logic          armed;

    // Clamp the requested window to the supported range.
    always_comb begin
        if (win_len < LO_W)      eff = LO_W;
        else if (win_len > HI_W) eff = HI_W;
        else                     eff = win_len;
    end

    fd_blank #(.BLANK(BLANK), .MINWIN(MINWIN), .CW(CW)) u_blank (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .eff(eff),
        .flush(flush), .armed(armed)
    );

    fd_window #(.MAXWIN(MAXWIN), .CW(CW)) u_win (
        .clk(clk), .rst_n(rst_n), .flush(flush), .bit_en(bit_en),
        .bit_in(bit_in), .eff(eff), .zcnt(zcnt)
    );

    fd_trip #(.CW(CW)) u_trip (
        .clk(clk), .rst_n(rst_n), .armed(armed), .zcnt(zcnt),
        .zmax(zmax_lim), .zmin(zmin_lim), .trip_clr(trip_clr),
        .fd_err(fd_err), .trip_out(trip_out), .cause(cause)
    );

    AST_WIN_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        (eff >= LO_W) && (eff <= HI_W)); // R2
endmodule

// File: tb/sim_bitwin_fast_detect.sv
module sim_bitwin_fast_detect;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b1;
    logic [5:0] win_len = 6'd8;
    logic [5:0] zmax_lim = 6'd32;
    logic [5:0] zmin_lim = 6'd0;
    logic       trip_clr = 1'b0;
    logic       fd_err;
    logic       trip_out;
    logic [1:0] cause;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // reference model state
    logic [31:0] m_hist;
    int          m_nacc;
    int          m_eff;
    logic        m_trip;
    logic [1:0]  m_cause;

    always #(PERIOD/2) clk = ~clk;

    bitwin_fast_detect u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .win_len(win_len), .zmax_lim(zmax_lim), .zmin_lim(zmin_lim),
        .trip_clr(trip_clr), .fd_err(fd_err), .trip_out(trip_out),
        .cause(cause)
    );

    function automatic int clampw(input int l);
        if (l < 4) return 4;
        if (l > 32) return 32;
        return l;
    endfunction

    function automatic int zeros(input logic [31:0] h, input int l);
        int z = 0;
        for (int i = 0; i < l; i++) if (!h[i]) z++;
        return z;
    endfunction

    function automatic logic [1:0] viol(input logic [31:0] h, input int l,
                                        input int nacc, input int zmx,
                                        input int zmn);
        int z = zeros(h, l);
        if (nacc < 32) return 2'b00;
        return {z < zmn, z > zmx};
    endfunction

    task automatic check(input string tag, input logic [3:0] act,
                         input logic [3:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: {err,trip,cause} actual=%b expected=%b at %0t",
                     tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_hist = '1; m_nacc = 0; m_eff = 4; m_trip = 0; m_cause = 0;
    endtask

    // One clock: drive at negedge, update model, check at next negedge.
    task automatic step(input logic en, input logic b, input logic clr,
                        input string tag);
        logic [1:0] pre;
        logic [1:0] post;
        int neff;
        bit_en = en; bit_in = b; trip_clr = clr;
        neff = clampw(int'(win_len));
        pre = viol(m_hist, m_eff, m_nacc, int'(zmax_lim), int'(zmin_lim));
        @(posedge clk);
        if (pre != 2'b00) begin
            m_trip = 1'b1; m_cause = m_cause | pre;
        end else if (clr) begin
            m_trip = 1'b0; m_cause = 2'b00;
        end
        if (neff != m_eff) begin
            m_hist = '1; m_nacc = 0; m_eff = neff;
        end else if (en) begin
            m_hist = {m_hist[30:0], b};
            if (m_nacc < 32) m_nacc++;
        end
        @(negedge clk);
        post = viol(m_hist, m_eff, m_nacc, int'(zmax_lim), int'(zmin_lim));
        check(tag, {fd_err, trip_out, cause}, {|post, m_trip, m_cause});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_en = 0; trip_clr = 0;
        @(posedge clk); @(negedge clk);
        model_reset();
        check("R1 reset", {fd_err, trip_out, cause}, 4'b0000);
        rst_n = 1'b1;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();

        // R2: request 2 acts as 4; max 2 zeros
        win_len = 6'd2; zmax_lim = 6'd2; zmin_lim = 6'd0;
        repeat (2) step(0, 1, 0, "R2 flush");
        repeat (32) step(1, 1, 0, "R2 fill");
        repeat (5) step(1, 0, 0, "R2 clamp low R5");
        step(1, 1, 1, "R2 clear");
        repeat (6) step(1, 1, 1, "R7 clear quiet");

        // R2: request 40 acts as 32; min 20 zeros -> under
        win_len = 6'd40; zmax_lim = 6'd32; zmin_lim = 6'd20;
        repeat (2) step(0, 1, 0, "R2 flush hi");
        for (int i = 0; i < 40; i++) step(1, (i % 3) != 0, 0, "R2 clamp high R6 R3");
        zmin_lim = 6'd0;
        repeat (3) step(1, 1, 1, "R7 clear after R6");

        // R4: zero maximum, all zeros; quiet for 31 bits, fires on 32nd
        win_len = 6'd8; zmax_lim = 6'd0; zmin_lim = 6'd0;
        repeat (2) step(0, 1, 0, "R9 flush");
        repeat (34) step(1, 0, 0, "R4 blanking edge");
        // R7: clear while fault persists must not drop the trip
        repeat (3) step(1, 0, 1, "R7 fault beats clear");
        // R8: idle cycles with bit_in toggling change nothing
        zmax_lim = 6'd8;
        repeat (6) step(0, 1, 0, "R8 idle");
        step(0, 0, 1, "R7 clear");
        zmax_lim = 6'd3;
        repeat (5) step(0, 0, 0, "R8 idle ignored bits");
        // R9: length change mid-stream restarts blanking
        win_len = 6'd16;
        repeat (20) step(1, 0, 0, "R9 restart blanking");
        repeat (16) step(1, 0, 0, "R9 armed again");
        zmax_lim = 6'd32;
        step(0, 1, 1, "R7 clear");

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            int dens;
            if ((n % 500) == 0) begin
                zmax_lim = 6'($urandom_range(33, 2));
                zmin_lim = 6'($urandom_range(6, 0));
            end
            if ($urandom_range(99, 0) == 0) win_len = 6'($urandom_range(40, 1));
            dens = ((n / 250) % 2 == 0) ? 30 : 70;
            step($urandom_range(9, 0) < 8, $urandom_range(99, 0) >= dens,
                 $urandom_range(19, 0) == 0, "R3 R5 R6 random");
        end

        do_reset();
        step(0, 1, 0, "R1 post reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule